// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether an I2C slave has been selected. It compares the first byte received after a START or repeated START against a stored 8-bit own-address register. Bits 7..1 of that register hold the seven upper address bits and bit 0 holds a direction compare bit. A mode input chooses between the 7-bit format and the 10-bit format. In 7-bit mode bit 0 of the register is ignored. In 10-bit mode all eight bits take part, so the direction bit is treated as an address bit.

When the first byte matches, the block raises an addressed flag and captures the direction bit that was received. The low byte of a 10-bit address is checked outside this block. Once that check succeeds, software sets bit 0 of the register to 1 through a dedicated single-bit write port. After that, the read header that follows a repeated START matches the stored value. The register also takes full-byte writes.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, aas_o and dir_o are 0 and addr_reg_o equals the RST_ADDR parameter (default 0x00).
- R2: With mode10_i = 0, a first byte matches when its bits 7..1 equal addr_reg_o bits 7..1, whatever bit 0 of either holds.
- R3: With mode10_i = 1, a first byte matches only when all 8 bits equal addr_reg_o, including bit 0.
- R4: In the clock cycle after a matching first byte (byte_vld_i = 1, first_byte_i = 1, stop_i = 0), aas_o is 1 and dir_o equals bit 0 of that byte.
- R5: In the clock cycle after a non-matching first byte, aas_o and dir_o are 0.
- R6: In the clock cycle after stop_i = 1, aas_o and dir_o are 0. This holds even when a matching first byte arrives in the same cycle.
- R7: A byte with first_byte_i = 0 leaves aas_o and dir_o unchanged.
- R8: reg_wr_i loads reg_wdata_i into the register by the next cycle. rbw_wr_i loads rbw_i into bit 0 only. When both are asserted in the same cycle, the full write wins.
- R9: A compare made in the same cycle as a register write uses the register value from before that write.
- R10: first_byte_i has no effect while byte_vld_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Received byte is valid this cycle |
| byte_i | input | 8 | Received byte |
| first_byte_i | input | 1 | Byte is the first one after a START or repeated START |
| stop_i | input | 1 | A STOP condition was seen |
| mode10_i | input | 1 | 0 selects 7-bit addressing, 1 selects 10-bit addressing |
| reg_wr_i | input | 1 | Full register write strobe |
| reg_wdata_i | input | 8 | Full register write data |
| rbw_wr_i | input | 1 | Write strobe for bit 0 only |
| rbw_i | input | 1 | New value for bit 0 |
| addr_reg_o | output | 8 | Current own-address register |
| aas_o | output | 1 | Addressed as slave |
| dir_o | output | 1 | Direction bit captured from the matching byte |

## Verification
Two pairs of events can land in the same cycle, and both are provoked on purpose.

The first pair is a register write and an address compare. The bench writes a new address in the same cycle that a byte equal to that new address arrives. It expects no match, because the compare still sees the old value. It then expects a match on the next first byte.

The second pair is a STOP and a matching first byte. The bench expects STOP to clear the flag.

Random traffic mixes writes, STOPs and near-matching bytes. Every cycle is judged against a reference model in the bench.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic {
    MODE_7B  = 1'b0,
    MODE_10B = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/i2c_am_reg.sv
module i2c_am_reg #(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rbw_wr_i,
  input  logic          rbw_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= RST_VAL;
    else if (wr_i)     q_o <= wdata_i;
    else if (rbw_wr_i) q_o[0] <= rbw_i;
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          [DW-1:0] rx_i,
  input  logic          [DW-1:0] ref_i,
  input  addr_mode_e             mode_i,
  output logic                   hit_o
);
  logic [DW-1:0] eq;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == 0) begin : g_rbw
      // direction bit is an address bit only in the 10-bit format
      assign eq[b] = (mode_i == MODE_7B) || (rx_i[b] == ref_i[b]);
    end else begin : g_addr
      assign eq[b] = (rx_i[b] == ref_i[b]);
    end
  end

  assign hit_o = &eq;
endmodule

// File: rtl/i2c_am_flag.sv
module i2c_am_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_en_i,
  input  logic hit_i,
  input  logic dir_bit_i,
  input  logic clr_i,
  output logic aas_o,
  output logic dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aas_o <= 1'b0;
      dir_o <= 1'b0;
    end else if (clr_i) begin
      aas_o <= 1'b0;
      dir_o <= 1'b0;
    end else if (cmp_en_i) begin
      aas_o <= hit_i;
      dir_o <= hit_i & dir_bit_i;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] RST_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          first_byte_i,
  input  logic          stop_i,
  input  logic          mode10_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          rbw_wr_i,
  input  logic          rbw_i,
  output logic [DW-1:0] addr_reg_o,
  output logic          aas_o,
  output logic          dir_o
);
  logic       hit;
  logic       cmp_en;
  addr_mode_e mode;

  assign mode   = mode10_i ? MODE_10B : MODE_7B;
  assign cmp_en = byte_vld_i & first_byte_i;

  i2c_am_reg #(.DW(DW), .RST_VAL(RST_ADDR)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .rbw_wr_i (rbw_wr_i),
    .rbw_i    (rbw_i),
    .q_o      (addr_reg_o)
  );

  i2c_am_cmp #(.DW(DW)) u_cmp (
    .rx_i   (byte_i),
    .ref_i  (addr_reg_o),
    .mode_i (mode),
    .hit_o  (hit)
  );

  i2c_am_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_en_i  (cmp_en),
    .hit_i     (hit),
    .dir_bit_i (byte_i[0]),
    .clr_i     (stop_i),
    .aas_o     (aas_o),
    .dir_o     (dir_o)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_vld_i,
  input logic [DW-1:0] byte_i,
  input logic          first_byte_i,
  input logic          stop_i,
  input logic          mode10_i,
  input logic          reg_wr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic          rbw_wr_i,
  input logic          rbw_i,
  input logic [DW-1:0] addr_reg_o,
  input logic          aas_o,
  input logic          dir_o
);
  a_r4_rise_needs_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aas_o) |-> $past(byte_vld_i && first_byte_i && !stop_i));

  a_r2_mismatch_7b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && first_byte_i && !mode10_i && byte_i[DW-1:1] != addr_reg_o[DW-1:1])
      |=> !aas_o && !dir_o);

  a_r3_mismatch_10b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && first_byte_i && mode10_i && byte_i != addr_reg_o) |=> !aas_o && !dir_o);

  a_r6_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !aas_o && !dir_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(byte_vld_i && first_byte_i) && !stop_i) |=> $stable(aas_o) && $stable(dir_o));

  a_r8_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> addr_reg_o == $past(reg_wdata_i));

  a_r8_reg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && !rbw_wr_i) |=> $stable(addr_reg_o));

  a_r4_dir_implies_aas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_o |-> aas_o);
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_vld_i   (byte_vld_i),
  .byte_i       (byte_i),
  .first_byte_i (first_byte_i),
  .stop_i       (stop_i),
  .mode10_i     (mode10_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .rbw_wr_i     (rbw_wr_i),
  .rbw_i        (rbw_i),
  .addr_reg_o   (addr_reg_o),
  .aas_o        (aas_o),
  .dir_o        (dir_o)
);

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0, first = 1'b0, stop = 1'b0, m10 = 1'b0;
  logic       wr = 1'b0, rbw_wr = 1'b0, rbw = 1'b0;
  logic [7:0] bdat = '0, wdat = '0;
  logic [7:0] areg;
  logic       aas, dir;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_reg = 8'h00;
  logic       m_aas = 1'b0, m_dir = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_match uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .byte_i(bdat),
    .first_byte_i(first), .stop_i(stop), .mode10_i(m10),
    .reg_wr_i(wr), .reg_wdata_i(wdat), .rbw_wr_i(rbw_wr), .rbw_i(rbw),
    .addr_reg_o(areg), .aas_o(aas), .dir_o(dir)
  );

  function automatic logic ref_hit(logic [7:0] b, logic [7:0] r, logic mode);
    return mode ? (b == r) : (b[7:1] == r[7:1]);
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    check(tag, {aas, dir, areg}, {m_aas, m_dir, m_reg});
  endtask

  // drive at negedge, model the edge, compare just after it
  task automatic step(input logic v, input logic f, input logic [7:0] b, input logic s,
                      input logic md, input logic w, input logic [7:0] wd,
                      input logic rw, input logic rv, input string tag);
    logic hit;
    vld = v; first = f; bdat = b; stop = s; m10 = md;
    wr = w; wdat = wd; rbw_wr = rw; rbw = rv;
    @(posedge clk);
    #1;
    hit = v && f && ref_hit(b, m_reg, md);
    if (s) begin
      m_aas = 1'b0; m_dir = 1'b0;
    end else if (v && f) begin
      m_aas = hit; m_dir = hit & b[0];
    end
    if (w) m_reg = wd;
    else if (rw) m_reg[0] = rv;
    cmp_all(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    string tag;
    void'($urandom(32'h1C2A));
    #10;
    check("R1", {aas, dir, areg}, 10'h000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", {aas, dir, areg}, 10'h000);

    // R8: full write, then rbw-only write, then both at once
    step(0,0,0,0,0, 1,8'hA5, 0,0, "R8");
    step(0,0,0,0,0, 0,8'h00, 1,0, "R8");
    step(0,0,0,0,0, 1,8'hA5, 1,0, "R8");
    // R2: 7-bit mode ignores bit 0 of both sides
    step(1,1,8'hA4,0,0, 0,0,0,0, "R2");
    check("R4", {aas, dir}, 2'b10);
    step(1,1,8'hA5,0,0, 0,0,0,0, "R4");
    // R7: data bytes leave the flag alone
    step(1,0,8'h00,0,0, 0,0,0,0, "R7");
    // R3/R5: 10-bit mode needs bit 0 to match
    step(1,1,8'hA4,0,1, 0,0,0,0, "R3");
    check("R5", {aas, dir}, 2'b00);
    // 10-bit header flow: write header, match, software sets rbw, read header after restart
    step(0,0,0,0,1, 1,8'hF2, 0,0, "R8");
    step(1,1,8'hF2,0,1, 0,0,0,0, "R3");
    step(1,0,8'h5A,0,1, 0,0,1,1, "R8");
    step(1,1,8'hF3,0,1, 0,0,0,0, "R3");
    check("R4", {aas, dir}, 2'b11);
    // R6: stop alongside a matching first byte
    step(1,1,8'hF3,1,1, 0,0,0,0, "R6");
    // R10: first_byte_i without valid
    step(0,1,8'hF3,0,1, 0,0,0,0, "R10");
    // R9: write and compare in the same cycle
    step(0,0,0,0,0, 1,8'h50, 0,0, "R8");
    step(1,1,8'h60,0,0, 1,8'h60, 0,0, "R9");
    step(1,1,8'h60,0,0, 0,0,0,0, "R9");
    step(1,1,8'h61,0,1, 0,0,0,0, "R5");

    for (int i = 0; i < 3000; i++) begin
      logic v, f, s, md, w, rw, rv;
      logic [7:0] b, wd;
      v  = ($urandom % 4) != 0;
      f  = ($urandom % 3) == 0;
      s  = ($urandom % 10) == 0;
      md = $urandom % 2;
      w  = ($urandom % 12) == 0;
      rw = ($urandom % 10) == 0;
      rv = $urandom % 2;
      wd = 8'($urandom);
      b  = (($urandom % 2) == 0) ? {m_reg[7:1], 1'($urandom)} : 8'($urandom);
      if (s) tag = "R6";
      else if (v && f) tag = md ? "R3" : "R2";
      else if (f) tag = "R10";
      else tag = "R7";
      step(v, f, b, s, md, w, wd, rw, rv, tag);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule